// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a nine-tap FIR filter with no multiplier. Each accepted 12-bit two's complement sample is pushed into a tap delay line. The block then steps through the bit positions of every stored sample, one position per clock, starting at the least significant bit. At each step it takes the bit at that position from every tap and uses those bits as an address into precomputed tables. Each table entry holds the sum of the coefficients whose address bit is set. The table result is weighted by two to the power of the bit position and added into an accumulator. At the sign position the weighted value is subtracted instead.

The nine taps are served by two tables, one for four taps (16 entries) and one for five taps (32 entries). The outputs of the two tables are added before accumulation. Two coefficient sets are built in: a smoothing low-pass set and an alternating-sign high-pass set. A select input chooses the set, and it is captured together with each sample. A result takes twelve cycles to compute. During those cycles the input handshake is closed, and the result then appears with a one-cycle valid pulse.

Top module: `dafir_top`

## Requirements
- R1: After synchronous reset, in_ready is 1, out_valid is 0, out_data is 0 and every tap holds zero.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 for the next 12 cycles and returns to 1 in the cycle in which out_valid is high, so a new sample can be accepted on the very next edge.
- R3: out_valid is 1 for exactly one cycle: the cycle that follows the 12th clock edge after the accepting edge.
- R4: out_data is y = sum over k=0..8 of c[k]*x[n-k]. Here x[n] is the sample just accepted, x[n-k] is the k-th earlier accepted sample (zero if none since reset), and the result is signed, 24 bits wide and bit-exact.
- R5: in_set=0 selects coefficients c[0..8] = 2,7,16,27,32,27,16,7,2. in_set=1 selects 1,-4,9,-21,30,-21,9,-4,1. The value in effect is the one present on the accepting edge.
- R6: The sign bit (bit 11) of each sample carries weight -2048, so full-scale samples -2048 and 2047 give exact results.
- R7: in_valid asserted while in_ready is 0 is ignored: the sample does not enter the delay line and does not change any later result.
- R8: Changing in_set while a result is being computed has no effect on that result.
- R9: out_data holds its last result, unchanged, until the next out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 12 | Two's complement input sample |
| in_set | input | 1 | Coefficient set select, captured with the sample |
| out_valid | output | 1 | One-cycle pulse: out_data is new |
| out_data | output | 24 | Signed filter output |

## Verification
The bench drives full-scale samples, including runs of -2048 and mixes of -2048 and 2047. A design that adds the sign slice instead of subtracting it, or that sign-extends the table value wrongly, gives large errors on exactly these samples. An impulse through each coefficient set exposes tap-order and table-addressing mistakes, because each output must reproduce one coefficient.

While a computation is in progress, the bench holds in_valid high with junk data and flips the set select. A design that leaks either into the delay line or into the captured set produces a wrong value on the following outputs. The bench also checks the exact twelve-cycle ready gap, back-to-back acceptance, and that out_data holds between pulses, so a step-counter off by one or an extra valid pulse is caught.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } dafir_phase_e;

  function automatic int part_taps(input int taps, input int split, input int idx);
    return (idx == 0) ? split : taps - split;
  endfunction

  function automatic int part_base(input int split, input int idx);
    return (idx == 0) ? 0 : split;
  endfunction

endpackage

// File: rtl/dafir_tapline.sv
module dafir_tapline #(
  parameter int TAPS   = 9,
  parameter int SAMP_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SAMP_W-1:0] din,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [TAPS-1:0]   slice
);

  logic [TAPS-1:0][SAMP_W-1:0] taps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= '0;
    end else if (load) begin
      taps_q[0] <= din;
      for (int k = 1; k < TAPS; k++) taps_q[k] <= taps_q[k-1];
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) slice[k] = taps_q[k][bit_idx];
  end

  // R7: without a load the stored samples stay untouched
  a_r7_taps_frozen: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(taps_q));

endmodule

// File: rtl/dafir_slice_rom.sv
module dafir_slice_rom #(
  parameter int TAPS   = 9,
  parameter int COEF_W = 8,
  parameter int N      = 4,
  parameter int BASE   = 0,
  parameter int SUM_W  = 13,
  parameter logic [TAPS*COEF_W-1:0] COEF_A = '0,
  parameter logic [TAPS*COEF_W-1:0] COEF_B = '0
) (
  input  logic                    set_sel,
  input  logic [N-1:0]            addr,
  output logic signed [SUM_W-1:0] sum
);

  localparam int DEPTH = 1 << N;

  function automatic logic signed [SUM_W-1:0] entry(input int e);
    logic [TAPS*COEF_W-1:0]    cv;
    logic signed [COEF_W-1:0]  c;
    logic signed [SUM_W-1:0]   s;
    cv = (e >= DEPTH) ? COEF_B : COEF_A;
    s  = '0;
    for (int j = 0; j < N; j++) begin
      if (e[j]) begin
        c = cv[(BASE+j)*COEF_W +: COEF_W];
        s = s + SUM_W'(c);
      end
    end
    return s;
  endfunction

  logic signed [SUM_W-1:0] tbl [2*DEPTH];

  for (genvar e = 0; e < 2*DEPTH; e++) begin : g_entry
    assign tbl[e] = entry(e);
  end

  assign sum = tbl[{set_sel, addr}];

endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
  parameter int SUM_W = 13,
  parameter int ACC_W = 24,
  parameter int IDX_W = 4,
  parameter int LAST  = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    step,
  input  logic [IDX_W-1:0]        bit_idx,
  input  logic signed [SUM_W-1:0] slice_sum,
  output logic signed [ACC_W-1:0] acc_next
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] term;

  always_comb begin
    term     = ACC_W'(slice_sum) <<< bit_idx;
    acc_next = (bit_idx == LAST_IDX) ? acc_q - term : acc_q + term;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (step)    acc_q <= acc_next;
  end

  // R4: every new result starts from an empty accumulator
  a_r4_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc_q == '0));

endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
  parameter int TAPS   = 9,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 8,
  parameter int SPLIT  = 4,
  parameter logic [TAPS*COEF_W-1:0] COEF_A = {8'd2, 8'd7, 8'd16, 8'd27, 8'd32,
                                               8'd27, 8'd16, 8'd7, 8'd2},
  parameter logic [TAPS*COEF_W-1:0] COEF_B = {8'd1, 8'(-4), 8'd9, 8'(-21), 8'd30,
                                               8'(-21), 8'd9, 8'(-4), 8'd1},
  localparam int OUT_W = SAMP_W + COEF_W + $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic             in_set,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  import dafir_pkg::*;

  localparam int IDX_W = $clog2(SAMP_W);
  localparam int SUM_W = COEF_W + $clog2(TAPS) + 1;
  localparam int LAST  = SAMP_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

  dafir_phase_e           phase_q;
  logic [IDX_W-1:0]       bit_q;
  logic                   set_q;
  logic                   out_valid_q;
  logic [OUT_W-1:0]       out_q;
  logic                   accept;
  logic                   running;
  logic [TAPS-1:0]        slice;
  logic signed [SUM_W-1:0] part_sum [2];
  logic signed [SUM_W-1:0] slice_sum;
  logic signed [OUT_W-1:0] acc_next;

  assign running  = (phase_q == PH_RUN);
  assign in_ready = !running;
  assign accept   = in_valid && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      bit_q       <= '0;
      set_q       <= 1'b0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      out_valid_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_RUN;
        bit_q   <= '0;
        set_q   <= in_set;
      end else if (running) begin
        if (bit_q == LAST_IDX) begin
          phase_q     <= PH_IDLE;
          out_valid_q <= 1'b1;
          out_q       <= acc_next;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_q;

  dafir_tapline #(.TAPS(TAPS), .SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_taps (
    .clk(clk), .rst(rst), .load(accept), .din(in_sample),
    .bit_idx(bit_q), .slice(slice)
  );

  for (genvar g = 0; g < 2; g++) begin : g_part
    localparam int NP = part_taps(TAPS, SPLIT, g);
    localparam int BP = part_base(SPLIT, g);
    dafir_slice_rom #(
      .TAPS(TAPS), .COEF_W(COEF_W), .N(NP), .BASE(BP), .SUM_W(SUM_W),
      .COEF_A(COEF_A), .COEF_B(COEF_B)
    ) u_rom (
      .set_sel(set_q), .addr(slice[BP +: NP]), .sum(part_sum[g])
    );
  end

  assign slice_sum = part_sum[0] + part_sum[1];

  dafir_accum #(.SUM_W(SUM_W), .ACC_W(OUT_W), .IDX_W(IDX_W), .LAST(LAST)) u_acc (
    .clk(clk), .rst(rst), .clear(accept), .step(running),
    .bit_idx(bit_q), .slice_sum(slice_sum), .acc_next(acc_next)
  );

  // checker counter: cycles since the accepting edge
  logic [IDX_W:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                 since_q <= '0;
    else if (accept)         since_q <= 1;
    else if (out_valid_q)    since_q <= '0;
    else if (since_q != '0)  since_q <= since_q + 1'b1;
  end

  // R3: valid appears exactly after SAMP_W steps
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since_q == (IDX_W+1)'(SAMP_W + 1)));
  // R3: single-cycle pulse
  a_r3_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R2: handshake closed during computation
  a_r2_ready_low: assert property (@(posedge clk) disable iff (rst)
    (since_q != '0 && since_q <= (IDX_W+1)'(SAMP_W)) |-> !in_ready);
  // R8: captured coefficient set stays fixed while running
  a_r8_set_held: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(set_q));
  // R9: output holds between pulses
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> ($stable(out_data) || out_valid));

endmodule

// File: tb/tb_dafir_top.sv
module tb_dafir_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_sample = '0;
  logic        in_set = 1'b0;
  logic        out_valid;
  logic [23:0] out_data;

  always #10 clk = ~clk;

  dafir_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_set(in_set), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  int hist [9];
  int ca [9] = '{2, 7, 16, 27, 32, 27, 16, 7, 2};
  int cb [9] = '{1, -4, 9, -21, 30, -21, 9, -4, 1};
  int expq [$];
  int last_out = 0;
  int lcg = 12345;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int sel);
    int s = 0;
    for (int k = 0; k < 9; k++) s += (sel != 0 ? cb[k] : ca[k]) * hist[k];
    return s;
  endfunction

  // driver: caller is just after a negedge with in_ready expected high
  task automatic send(input int x, input int sel, input bit junk);
    int e;
    int gap_bad = 0;
    int hold_bad = 0;
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_sample = x[11:0];
    in_set    = sel[0];
    for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    e = model(sel);
    expq.push_back(e);
    @(posedge clk);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (junk && i <= 11) begin
        in_valid  = 1'b1;
        in_sample = ~x[11:0] ^ 12'(i);
        in_set    = ~sel[0];
      end else begin
        in_valid = 1'b0;
      end
      if (in_ready || out_valid) gap_bad++;
      if ($signed(out_data) != last_out) hold_bad++;
    end
    chk(gap_bad == 0, "R2 ready low / R3 no early valid", gap_bad, 0);
    chk(hold_bad == 0, "R9 output held", hold_bad, 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && in_ready, "R3 valid after 12 steps, R2 ready back",
        {out_valid, in_ready}, 3);
    last_out = e;
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected output", $signed(out_data), 0);
      end else begin
        int e;
        e = expq.pop_front();
        chk($signed(out_data) == e, "R4 result", $signed(out_data), e);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 9; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 no valid after reset", out_valid, 0);
    chk(out_data == '0, "R1 output zero after reset", out_data, 0);

    // R4 / R5: impulse through the low-pass set
    send(1, 0, 0);
    for (int i = 0; i < 8; i++) send(0, 0, 0);
    // R5: impulse through the high-pass set
    send(1, 1, 0);
    for (int i = 0; i < 8; i++) send(0, 1, 0);
    // R6: full-scale negative and positive runs
    for (int i = 0; i < 9; i++) send(-2048, 0, 0);
    for (int i = 0; i < 9; i++) send((i % 2) ? 2047 : -2048, 1, 0);
    send(2047, 0, 0);
    // R7 / R8: junk and set flips while busy
    for (int i = 0; i < 10; i++) send(i * 311 - 1500, i % 2, 1);
    // idle gap then mixed pseudo-random samples
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R3 no valid while idle", out_valid, 0);
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 1103515245 + 12345;
      send(((lcg >>> 8) % 4096) - 2048 + (((lcg >>> 8) % 4096) < 0 ? 4096 : 0),
           (lcg >>> 20) & 1, i % 3 == 0);
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4 all results produced", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule